// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block brings an SDRAM out of power-up and then keeps it refreshed. After reset it waits a programmable pause with clock enable and every data-mask line held high. It then precharges all banks, runs a burst of auto-refresh commands and loads the mode register from a set of configuration inputs. Once the mode register has been written it raises an init-done flag and hands the command bus to the normal access controller.

From then on an interval timer, derived from the clock period and the refresh budget (4096 refreshes per 64 ms by default, one about every 15.6 µs), raises a refresh request. The access controller finishes its own work, closes nothing itself and answers with a grant. The sequencer then owns the command bus: it precharges all banks, waits the precharge time, issues one auto-refresh, waits the bank cycle time and drops the request. A request that is still open when the next interval ends sets a sticky late flag.

The configuration inputs are checked before the mode register is written. An illegal combination is never programmed; the sequencer flags it and keeps re-checking every cycle until the inputs become legal.

Top module: `sdr_initref_seq`

## Requirements
- R1: For PAUSE_CYC cycles after reset release (cycles 0 to PAUSE_CYC-1) the command is NOP (`cmd_n` = 4'b0111), `cke` is 1, every `dqm` bit is 1 and `init_done` is 0; `cke` stays 1 at all times.
- R2: In cycle PAUSE_CYC the command is precharge-all: `cmd_n` = 4'b0010 with `addr[10]` = 1 and all other address bits 0; `ba` is 0 for every command.
- R3: Eight auto-refresh commands (`cmd_n` = 4'b0001, address 0) follow, the first TRP_CYC cycles after the precharge and each next one TRC_CYC cycles after the previous one (TRP_CYC = ceil(20 ns / period), TRC_CYC = ceil(70 ns / period)).
- R4: If the configuration is legal, the mode register set (`cmd_n` = 4'b0000) is issued TRC_CYC+1 cycles after the last initial refresh, with `addr[2:0]` = length code, `addr[3]` = interleave, `addr[6:4]` = CAS latency, `addr[9]` = single-location write, all other address bits 0; configuration changes after that have no effect.
- R5: A configuration with CAS latency other than 2 or 3, a length code of 4, 5 or 6, or interleave together with length code 7 (full page) is illegal: no mode register set is issued, `mode_err` is 1 from the next cycle and `init_done` stays 0. The inputs are re-checked every cycle; the cycle after they are legal the mode register set is issued and `mode_err` returns to 0.
- R6: `init_done` rises and every `dqm` bit falls 2 cycles after the mode register set and both stay so until reset.
- R7: `ref_req` rises REFI_CYC cycles after `init_done` rises and a new interval starts every REFI_CYC cycles (REFI_CYC = floor(64 ms / 4096 / period)); a raised request stays high until its refresh completes.
- R8: After initialization, while no refresh is in service the command is NOP; a grant while `ref_req` is 0 starts nothing.
- R9: When `ref_gnt` and `ref_req` are both 1 in an idle cycle, precharge-all is issued in the next cycle, auto-refresh TRP_CYC cycles after it, and `ref_req` falls TRC_CYC cycles after the auto-refresh.
- R10: If an interval ends while `ref_req` is still 1, `ref_late` becomes 1 in the next cycle and stays 1 until reset; the open request is served by a single refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cas_lat | input | 3 | CAS latency to program (2 or 3) |
| cfg_interleave | input | 1 | 1 selects interleaved burst order |
| cfg_blen | input | 3 | Burst length code: 0..3 for 1,2,4,8; 7 for full page |
| cfg_wr_single | input | 1 | 1 makes writes single-location |
| ref_gnt | input | 1 | Access controller yields the command bus |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | DQM_W | Data mask lines, high until init is done |
| cmd_n | output | 4 | {chip select, row strobe, column strobe, write enable}, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank address |
| init_done | output | 1 | Initialization complete |
| mode_err | output | 1 | Configuration rejected |
| ref_req | output | 1 | Refresh request to the access controller |
| ref_late | output | 1 | Sticky: a refresh interval ended with its request unserved |

## Verification
The hardest state to reach is an interval expiring while a request is still open, since it needs the access controller to withhold its grant for more than a whole refresh interval after initialization. The bench drives the grant from a small controller model whose policy it switches: first granting permanently (so grants arrive with no request), then refusing for more than two intervals to force the late flag, then answering each request. The illegal-configuration path is reached by holding three different illegal settings across the mode-check point before releasing a legal one, and a second reset reruns the sequence with another mode word.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_PRE,
        ST_WRP,
        ST_REF,
        ST_WRC,
        ST_CHK,
        ST_MRS,
        ST_WMRD,
        ST_IDLE
    } seq_state_e;

    localparam int MODE_W = 10;

endpackage

// File: rtl/sdr_mode_check.sv
module sdr_mode_check
    import sdr_seq_pkg::*;
#(
    parameter bit FULL_PAGE_EN = 1'b1
) (
    input  logic [2:0]        cas_lat,
    input  logic              interleave,
    input  logic [2:0]        blen,
    input  logic              wr_single,
    output logic              legal,
    output logic [MODE_W-1:0] word
);

    logic cas_ok;
    logic len_ok;

    assign cas_ok = (cas_lat == 3'd2) || (cas_lat == 3'd3);

    generate
        if (FULL_PAGE_EN) begin : g_fp
            // full page only with sequential order
            assign len_ok = (blen <= 3'd3) || ((blen == 3'd7) && !interleave);
        end else begin : g_nofp
            assign len_ok = (blen <= 3'd3);
        end
    endgenerate

    assign legal = cas_ok && len_ok;
    assign word  = {wr_single, 2'b00, cas_lat, interleave, blen};

endmodule

// File: rtl/sdr_refi_timer.sv
module sdr_refi_timer #(
    parameter int REFI_CYC = 3125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic svc_done,
    output logic req,
    output logic late
);

    localparam int TW = $clog2(REFI_CYC + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          pend;
        logic          late;
    } tmr_t;

    tmr_t q, d;
    logic expire;

    always_comb begin
        d      = q;
        expire = 1'b0;
        if (!run) begin
            d.cnt = TW'(REFI_CYC - 1);
        end else if (q.cnt == '0) begin
            expire = 1'b1;
            d.cnt  = TW'(REFI_CYC - 1);
            d.pend = 1'b1;
            d.late = q.late | q.pend;
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
        if (svc_done && !expire) begin
            d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= TW'(REFI_CYC - 1);
            q.pend <= 1'b0;
            q.late <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign req  = q.pend;
    assign late = q.late;

    AST_LATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        late |=> late); // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !svc_done) |=> req); // R7

endmodule

// File: rtl/sdr_init_fsm.sv
module sdr_init_fsm
    import sdr_seq_pkg::*;
#(
    parameter int PAUSE_CYC = 40000,
    parameter int TRP_CYC   = 4,
    parameter int TRC_CYC   = 14,
    parameter int TMRD_CYC  = 2,
    parameter int INIT_REFS = 8,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_pend,
    input  logic              ref_gnt,
    input  logic              mode_legal,
    input  logic [MODE_W-1:0] mode_word,
    output logic [3:0]        cmd_n,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done,
    output logic              mode_err,
    output logic              svc_done
);

    localparam int MAXW = (PAUSE_CYC > TRC_CYC) ? PAUSE_CYC : TRC_CYC;
    localparam int CW   = $clog2(MAXW + 1);
    localparam int NW   = $clog2(INIT_REFS + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CW-1:0]     cnt;
        logic [NW-1:0]     nref;
        logic [MODE_W-1:0] word;
        logic              done;
        logic              err;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d        = q;
        svc_done = 1'b0;
        case (q.state)
            ST_PAUSE: begin
                if (q.cnt == '0) d.state = ST_PRE;
                else             d.cnt   = q.cnt - 1'b1;
            end
            ST_PRE: begin
                d.state = ST_WRP;
                d.cnt   = CW'(TRP_CYC - 2);
            end
            ST_WRP: begin
                if (q.cnt == '0) d.state = ST_REF;
                else             d.cnt   = q.cnt - 1'b1;
            end
            ST_REF: begin
                d.state = ST_WRC;
                d.cnt   = CW'(TRC_CYC - 2);
                if (!q.done) d.nref = q.nref + 1'b1;
            end
            ST_WRC: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (q.done) begin
                    d.state  = ST_IDLE;
                    svc_done = 1'b1;
                end else if (q.nref == NW'(INIT_REFS)) begin
                    d.state = ST_CHK;
                end else begin
                    d.state = ST_REF;
                end
            end
            ST_CHK: begin
                if (mode_legal) begin
                    d.word  = mode_word;
                    d.err   = 1'b0;
                    d.state = ST_MRS;
                end else begin
                    d.err = 1'b1;
                end
            end
            ST_MRS: begin
                d.state = ST_WMRD;
                d.cnt   = CW'(TMRD_CYC - 2);
            end
            ST_WMRD: begin
                if (q.cnt == '0) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_IDLE: begin
                if (ref_pend && ref_gnt) d.state = ST_PRE;
            end
            default: d.state = ST_PAUSE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_PAUSE;
            q.cnt   <= CW'(PAUSE_CYC - 1);
            q.nref  <= '0;
            q.word  <= '0;
            q.done  <= 1'b0;
            q.err   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        cmd_n = CMD_NOP;
        addr  = '0;
        case (q.state)
            ST_PRE: begin
                cmd_n    = CMD_PRE;
                addr[10] = 1'b1;
            end
            ST_REF: cmd_n = CMD_REF;
            ST_MRS: begin
                cmd_n            = CMD_MRS;
                addr[MODE_W-1:0] = q.word;
            end
            default: ;
        endcase
    end

    assign init_done = q.done;
    assign mode_err  = q.err;

    AST_REFRESH_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.state == ST_PRE) |-> $past(ref_gnt)); // R9
    AST_MRS_LEGAL_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n == CMD_MRS) |-> ((addr[6:4] == 3'd2 || addr[6:4] == 3'd3)
                               && !(addr[3] && addr[2:0] == 3'd7)
                               && addr[2:0] != 3'd4 && addr[2:0] != 3'd5
                               && addr[2:0] != 3'd6)); // R4
    AST_ERR_BLOCKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> !init_done); // R5
    AST_DONE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R6

endmodule

// File: rtl/sdr_initref_seq.sv
module sdr_initref_seq
    import sdr_seq_pkg::*;
#(
    parameter int CLK_PS        = 5000,
    parameter int PAUSE_NS      = 200000,
    parameter int TRP_NS        = 20,
    parameter int TRC_NS        = 70,
    parameter int TMRD_CYC      = 2,
    parameter int INIT_REFS     = 8,
    parameter int REF_PERIOD_NS = 64000000,
    parameter int REF_COUNT     = 4096,
    parameter int ADDR_W        = 12,
    parameter int BA_W          = 2,
    parameter int DQM_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_interleave,
    input  logic [2:0]        cfg_blen,
    input  logic              cfg_wr_single,
    input  logic              ref_gnt,
    output logic              cke,
    output logic [DQM_W-1:0]  dqm,
    output logic [3:0]        cmd_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done,
    output logic              mode_err,
    output logic              ref_req,
    output logic              ref_late
);

    localparam int PAUSE_RAW = (PAUSE_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int PAUSE_CYC = (PAUSE_RAW < 1) ? 1 : PAUSE_RAW;
    localparam int TRP_RAW   = (TRP_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int TRP_CYC   = (TRP_RAW < 2) ? 2 : TRP_RAW;
    localparam int TRC_RAW   = (TRC_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int TRC_CYC   = (TRC_RAW < 2) ? 2 : TRC_RAW;
    localparam int REFI_CYC  = ((REF_PERIOD_NS / REF_COUNT) * 1000) / CLK_PS;

    logic              legal;
    logic [MODE_W-1:0] word;
    logic              svc_done;

    sdr_mode_check #(.FULL_PAGE_EN(1'b1)) u_chk (
        .cas_lat    (cfg_cas_lat),
        .interleave (cfg_interleave),
        .blen       (cfg_blen),
        .wr_single  (cfg_wr_single),
        .legal      (legal),
        .word       (word)
    );

    sdr_init_fsm #(
        .PAUSE_CYC (PAUSE_CYC),
        .TRP_CYC   (TRP_CYC),
        .TRC_CYC   (TRC_CYC),
        .TMRD_CYC  (TMRD_CYC),
        .INIT_REFS (INIT_REFS),
        .ADDR_W    (ADDR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_pend   (ref_req),
        .ref_gnt    (ref_gnt),
        .mode_legal (legal),
        .mode_word  (word),
        .cmd_n      (cmd_n),
        .addr       (addr),
        .init_done  (init_done),
        .mode_err   (mode_err),
        .svc_done   (svc_done)
    );

    sdr_refi_timer #(.REFI_CYC(REFI_CYC)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (init_done),
        .svc_done (svc_done),
        .req      (ref_req),
        .late     (ref_late)
    );

    assign cke = 1'b1;
    assign dqm = {DQM_W{~init_done}};
    assign ba  = '0;

    AST_DQM_TRACKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dqm[0]) |-> $rose(init_done)); // R6
    AST_NO_REQ_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !ref_req); // R7

endmodule

// File: tb/sim_sdr_initref_seq.sv
module sim_sdr_initref_seq;

    localparam int P    = 20;   // 100 ns pause at 5 ns
    localparam int TRP  = 4;    // 20 ns
    localparam int TRC  = 14;   // 70 ns
    localparam int TMRD = 2;
    localparam int NREF = 8;
    localparam int REFI = 120;  // 600 ns per refresh
    localparam int TC   = P + TRP + NREF * TRC;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cas = 3'd3;
    logic        il = 1'b1;
    logic [2:0]  bl = 3'd7;
    logic        ws = 1'b0;
    logic        gnt = 1'b0;
    logic        cke;
    logic [7:0]  dqm;
    logic [3:0]  cmd_n;
    logic [11:0] addr;
    logic [1:0]  ba;
    logic        done, err, req, late;

    int checks = 0;
    int failures = 0;
    int policy = 0;
    int wd = 0;

    always #2.5 clk = ~clk;

    sdr_initref_seq #(
        .CLK_PS(5000), .PAUSE_NS(100), .REF_PERIOD_NS(4096 * 600)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cas), .cfg_interleave(il),
        .cfg_blen(bl), .cfg_wr_single(ws), .ref_gnt(gnt), .cke(cke),
        .dqm(dqm), .cmd_n(cmd_n), .addr(addr), .ba(ba), .init_done(done),
        .mode_err(err), .ref_req(req), .ref_late(late)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit legal_cfg(input logic [2:0] c, input logic i, input logic [2:0] b);
        bit c_ok, b_ok;
        c_ok = (c == 3'd2) || (c == 3'd3);
        b_ok = (b < 3'd4) || (b == 3'd7 && !i);
        return c_ok && b_ok;
    endfunction

    // access-controller model driving the grant
    always @(posedge clk) begin
        #1;
        case (policy)
            1:       gnt = req;
            2:       gnt = 1'b1;
            default: gnt = 1'b0;
        endcase
    end

    // reference model, compared every cycle
    int k, mrs, svc, next_exp;
    bit m_err, m_req, m_late, m_done;
    logic [11:0] m_word;

    always @(negedge clk) begin
        logic [3:0]  e_cmd;
        logic [11:0] e_addr;
        string       tag;
        if (!rst_n) begin
            k = 0; mrs = -1; svc = -1; next_exp = -1;
            m_err = 0; m_req = 0; m_late = 0; m_word = '0;
        end else begin
            m_done = (mrs >= 0) && (k >= mrs + TMRD);
            e_cmd  = C_NOP;
            e_addr = '0;
            tag    = (k < P) ? "R1" : (m_done ? "R8" : "R3");
            if (k == P) begin e_cmd = C_PRE; e_addr = 12'h400; tag = "R2"; end
            for (int i = 0; i < NREF; i++)
                if (k == P + TRP + i * TRC) begin e_cmd = C_REF; tag = "R3"; end
            if (mrs >= 0 && k == mrs) begin e_cmd = C_MRS; e_addr = m_word; tag = "R4"; end
            if (k >= TC && mrs < 0) tag = "R5";
            if (svc >= 0 && k == svc) begin e_cmd = C_PRE; e_addr = 12'h400; tag = "R9"; end
            if (svc >= 0 && k == svc + TRP) begin e_cmd = C_REF; tag = "R9"; end
            chk({tag, " cmd"}, 32'(cmd_n), 32'(e_cmd));
            chk({tag, " addr"}, 32'(addr), 32'(e_addr));
            chk("R2 ba", 32'(ba), 32'd0);
            chk("R1 cke", 32'(cke), 32'd1);
            chk("R6 init_done", 32'(done), 32'(m_done));
            chk("R6 dqm", 32'(dqm), m_done ? 32'h00 : 32'hFF);
            chk("R5 mode_err", 32'(err), 32'(m_err));
            chk("R7 ref_req", 32'(req), 32'(m_req));
            chk("R10 ref_late", 32'(late), 32'(m_late));
            // next-cycle state
            if (k >= TC && mrs < 0) begin
                if (legal_cfg(cas, il, bl)) begin
                    mrs = k + 1; m_err = 0;
                    m_word = {2'b00, ws, 2'b00, cas, il, bl};
                end else begin
                    m_err = 1;
                end
            end
            if (mrs >= 0 && k == mrs + TMRD) next_exp = k + REFI;
            if (m_done && m_req && gnt && !(svc >= 0 && k <= svc + TRP + TRC - 1))
                svc = k + 1;
            if (next_exp >= 0 && k == next_exp - 1) begin
                if (m_req) m_late = 1;
                m_req = 1;
                next_exp = next_exp + REFI;
            end else if (svc >= 0 && k == svc + TRP + TRC - 1) begin
                m_req = 0;
            end
            k++;
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            failures++;
            $display("FAIL R1 watchdog actual=%0d expected<20000", wd);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;                                  // R1 pause, R2, R3
        cycles(TC + 2);
        cas = 3'd1; il = 1'b0; bl = 3'd3;              // R5 bad latency
        cycles(3);
        cas = 3'd3; bl = 3'd5;                         // R5 bad length code
        cycles(3);
        cas = 3'd3; il = 1'b0; bl = 3'd3; ws = 1'b1;   // R4 word 0x233
        cycles(3);
        cas = 3'd1; il = 1'b1; bl = 3'd7;              // R4 ignored after MRS
        policy = 2;                                    // R8 grant without request
        while (!req) cycles(1);
        cycles(30);                                    // R9 immediate service
        policy = 0;
        cycles(2 * REFI + 40);                         // R10 late flag
        policy = 1;
        cycles(3 * REFI);                              // R7, R9 answered requests
        rst_n = 1'b0;
        cas = 3'd2; il = 1'b1; bl = 3'd2; ws = 1'b0;   // R4 word 0x02A
        cycles(2);
        rst_n = 1'b1;
        cycles(TC + 3 * REFI);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule